// File: doc/BRIEF.md
# RMII Receive Elastic Buffer

This block sits between the receive side of a fast-Ethernet transceiver and the MAC-facing reduced media-independent interface. Received dibits arrive on a clock recovered from the line. They are written into a small asynchronous FIFO, and on the other side they are read out in the 50 MHz reference clock domain that the MAC samples. Because the two clocks are nominally equal but never identical, the FIFO first collects a programmable amount of data. Only then does it start playing the data out, so that a whole packet can pass without the buffer running dry or spilling over.

The MAC sees two status lines. A carrier/valid line rises as soon as the first dibit of a packet is buffered. A separate data-valid line rises only once playout starts, so the MAC never has to pull data-valid apart from carrier. An error line carries per-dibit receive errors, and it stays high for the rest of a packet once the buffer has overflowed or underflowed. In the 10 Mb/s mode the recovered clock runs ten times slower, and each output dibit is held for ten reference clocks.

A 2-bit start code trades latency against tolerance to clock offset. Each packet ends with a marker slot written into the FIFO, so the read side knows exactly when the last dibit has gone out.

Top module: `rmii_rx_elastic`

## Requirements
- R1: At 100 Mb/s (slow_mode=0), every dibit written while rec_valid is high appears on mac_rxd exactly once and in order, one per reference clock, with mac_rx_dv high in exactly those cycles.
- R2: Playout starts once the buffered count reaches the start level set by start_code: code 1 gives 2 dibits (4 bits), code 2 gives 4 dibits, code 3 gives 6 dibits and code 0 gives 8 dibits (16 bits). Each code step therefore delays the first output dibit by two more written dibits.
- R3: With slow_mode=1, each dibit is held on mac_rxd for exactly 10 reference clocks, so a packet of N dibits keeps mac_rx_dv high for 10*N cycles.
- R4: mac_crs_dv rises when the first dibit of a packet is available in the buffer, which is before mac_rx_dv rises. mac_rx_dv is never high while mac_crs_dv is low.
- R5: A dibit written with rec_err=1 is presented with mac_rx_er=1, and a dibit written with rec_err=0 is presented with mac_rx_er=0.
- R6: During playout, if the buffered count exceeds the limit 2*S-1 dibits (3, 7, 11 or 15 for start level S), mac_rx_er goes high for the rest of the packet. A clock offset that stays inside the limit produces no error.
- R7: During playout, if the buffer is empty when a dibit is due before the packet has ended, mac_rx_er goes high for the rest of the packet.
- R8: Whenever mac_crs_dv is low, mac_rxd is 00 and mac_rx_dv and mac_rx_er are low.
- R9: After an overflow or underflow, the rest of the packet is discarded up to its end marker. The next packet is then delivered cleanly.
- R10: mac_crs_dv and mac_rx_dv fall together in the cycle after the last dibit of a packet has been presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | 50 MHz reference clock, MAC side |
| ref_rst_n | input | 1 | Active-low asynchronous reset, reference domain |
| rec_clk | input | 1 | Recovered receive clock |
| rec_rst_n | input | 1 | Active-low asynchronous reset, recovered domain |
| rec_valid | input | 1 | Packet active; one dibit per rec_clk while high |
| rec_dibit | input | 2 | Received dibit |
| rec_err | input | 1 | Receive error flag for this dibit |
| slow_mode | input | 1 | 1 = 10 Mb/s (hold each dibit 10 clocks), 0 = 100 Mb/s |
| start_code | input | 2 | Start-threshold code (1,2,3,0 = 4,8,12,16 bits) |
| mac_rxd | output | 2 | Dibit toward the MAC |
| mac_crs_dv | output | 1 | Carrier / data-valid toward the MAC |
| mac_rx_dv | output | 1 | Separate data-valid toward the MAC |
| mac_rx_er | output | 1 | Receive error toward the MAC |

## Verification
A dibit that is popped at a reference edge shows up on mac_rxd one edge later. In the 100 Mb/s mode each mac_rx_dv cycle carries a new dibit. In the 10 Mb/s mode a new dibit comes on every tenth cycle, counted from the rise of mac_rx_dv, so the bench samples on falling edges and takes a value every cycle or every tenth cycle to match. The latency from a write to playout includes a synchronizer whose delay depends on clock phase. For that reason the start threshold is checked as the difference between codes, measured in dibits written before mac_rx_dv rises, and the checks on packet end and on errors wait for mac_crs_dv to fall before comparing.

// File: rtl/rmii_rx_elastic_pkg.sv
`timescale 1ns/1ps
package rmii_rx_elastic_pkg;

  typedef struct packed {
    logic       eop;
    logic       err;
    logic [1:0] dibit;
  } slot_t;

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_RUN, ST_FLUSH} rd_state_t;

  // start level in dibits for a 2-bit code; code 0 wraps to the largest
  function automatic logic [4:0] start_dibits(input logic [1:0] code);
    return (code == 2'd0) ? 5'd8 : {2'b00, code, 1'b0};
  endfunction

  // highest fill (dibits) tolerated during playout: start plus margin
  function automatic logic [4:0] fill_limit(input logic [1:0] code);
    return (start_dibits(code) << 1) - 5'd1;
  endfunction

endpackage

// File: rtl/rmii_rx_sync.sv
`timescale 1ns/1ps
module rmii_rx_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/rmii_rx_wr.sv
`timescale 1ns/1ps
module rmii_rx_wr
  import rmii_rx_elastic_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic [1:0]    dibit,
  input  logic          err,
  input  logic [AW:0]   rgray_s,
  output logic          we,
  output logic [AW-1:0] waddr,
  output slot_t         wslot,
  output logic [AW:0]   wgray
);
  localparam logic [AW:0] DEPTH_P = (AW+1)'(1) << AW;

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW-1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [AW:0] wbin, wbin_n;
  logic        prev_valid, eop_pend, eop_need, full;

  assign full     = (wbin - g2b(rgray_s)) == DEPTH_P;
  assign eop_need = eop_pend | (prev_valid & ~valid);
  assign waddr    = wbin[AW-1:0];
  assign wbin_n   = wbin + (AW+1)'(1);

  always_comb begin
    we    = 1'b0;
    wslot = '0;
    if (eop_need) begin
      we        = ~full;
      wslot.eop = 1'b1;
    end else if (valid && !full) begin
      we          = 1'b1;
      wslot.err   = err;
      wslot.dibit = dibit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin       <= '0;
      wgray      <= '0;
      prev_valid <= 1'b0;
      eop_pend   <= 1'b0;
    end else begin
      prev_valid <= valid;
      eop_pend   <= eop_need & full;
      if (we) begin
        wbin  <= wbin_n;
        wgray <= wbin_n ^ (wbin_n >> 1);
      end
    end
  end
endmodule

// File: rtl/rmii_rx_rd.sv
`timescale 1ns/1ps
module rmii_rx_rd
  import rmii_rx_elastic_pkg::*;
#(
  parameter int AW    = 4,
  parameter int RATIO = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slow,
  input  logic [1:0]    code,
  input  logic [AW:0]   wgray_s,
  input  slot_t         head,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [1:0]    rxd,
  output logic          crs,
  output logic          dv,
  output logic          er,
  output logic          pop,
  output logic          ev_start,
  output logic          ev_ovf,
  output logic          ev_unf,
  output logic          ev_eop
);
  localparam int DW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(RATIO - 1);

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW-1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  rd_state_t     st, st_n;
  logic [AW:0]   rbin, rbin_n, fill;
  logic [DW-1:0] div;
  logic [1:0]    rxd_n;
  logic          crs_n, dv_n, er_n, empty, tick;

  assign fill   = g2b(wgray_s) - rbin;
  assign empty  = (fill == '0);
  assign tick   = ~slow | (div == '0);
  assign raddr  = rbin[AW-1:0];
  assign rbin_n = rbin + (AW+1)'(1);

  always_comb begin
    st_n = st; rxd_n = rxd; crs_n = crs; dv_n = dv; er_n = er;
    pop = 1'b0; ev_start = 1'b0; ev_ovf = 1'b0; ev_unf = 1'b0; ev_eop = 1'b0;
    case (st)
      ST_IDLE: begin
        rxd_n = 2'b00; crs_n = 1'b0; dv_n = 1'b0; er_n = 1'b0;
        if (!empty) begin
          if (head.eop) pop = 1'b1;
          else begin st_n = ST_FILL; crs_n = 1'b1; end
        end
      end
      ST_FILL: begin
        if (fill >= (AW+1)'(start_dibits(code))) begin
          st_n = ST_RUN; ev_start = 1'b1;
        end
      end
      ST_RUN: begin
        if (fill > (AW+1)'(fill_limit(code))) begin
          ev_ovf = 1'b1; st_n = ST_FLUSH;
          er_n = 1'b1; dv_n = 1'b1; rxd_n = 2'b00;
        end else if (tick) begin
          if (empty) begin
            ev_unf = 1'b1; st_n = ST_FLUSH;
            er_n = 1'b1; dv_n = 1'b1; rxd_n = 2'b00;
          end else if (head.eop) begin
            pop = 1'b1; ev_eop = 1'b1; st_n = ST_IDLE;
            rxd_n = 2'b00; crs_n = 1'b0; dv_n = 1'b0; er_n = 1'b0;
          end else begin
            pop = 1'b1; rxd_n = head.dibit; er_n = head.err; dv_n = 1'b1;
          end
        end
      end
      ST_FLUSH: begin
        rxd_n = 2'b00; crs_n = 1'b1; dv_n = 1'b1; er_n = 1'b1;
        if (!empty) begin
          pop = 1'b1;
          if (head.eop) begin
            ev_eop = 1'b1; st_n = ST_IDLE;
            crs_n = 1'b0; dv_n = 1'b0; er_n = 1'b0;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; rbin <= '0; rgray <= '0; div <= '0;
      rxd <= 2'b00; crs <= 1'b0; dv <= 1'b0; er <= 1'b0;
    end else begin
      st <= st_n; rxd <= rxd_n; crs <= crs_n; dv <= dv_n; er <= er_n;
      if (pop) begin
        rbin  <= rbin_n;
        rgray <= rbin_n ^ (rbin_n >> 1);
      end
      if (st == ST_RUN && slow) div <= (div == DIV_LAST) ? '0 : div + DW'(1);
      else                      div <= '0;
    end
  end
endmodule

// File: rtl/rmii_rx_elastic.sv
`timescale 1ns/1ps
module rmii_rx_elastic
  import rmii_rx_elastic_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int SLOW_RATIO = 10
) (
  input  logic       ref_clk,
  input  logic       ref_rst_n,
  input  logic       rec_clk,
  input  logic       rec_rst_n,
  input  logic       rec_valid,
  input  logic [1:0] rec_dibit,
  input  logic       rec_err,
  input  logic       slow_mode,
  input  logic [1:0] start_code,
  output logic [1:0] mac_rxd,
  output logic       mac_crs_dv,
  output logic       mac_rx_dv,
  output logic       mac_rx_er
);
  localparam int AW = $clog2(DEPTH);

  slot_t         mem [DEPTH];
  slot_t         wslot, head;
  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   wgray, rgray, wgray_s, rgray_s;

  logic rd_pop, ev_start, ev_ovf, ev_unf, ev_eop;

  rmii_rx_wr #(.AW(AW)) u_wr (
    .clk(rec_clk), .rst_n(rec_rst_n), .valid(rec_valid), .dibit(rec_dibit),
    .err(rec_err), .rgray_s(rgray_s), .we(we), .waddr(waddr), .wslot(wslot),
    .wgray(wgray)
  );

  always_ff @(posedge rec_clk) begin
    if (we) mem[waddr] <= wslot;
  end
  assign head = mem[raddr];

  rmii_rx_sync #(.W(AW+1)) u_w2r (.clk(ref_clk), .rst_n(ref_rst_n), .d(wgray), .q(wgray_s));
  rmii_rx_sync #(.W(AW+1)) u_r2w (.clk(rec_clk), .rst_n(rec_rst_n), .d(rgray), .q(rgray_s));

  rmii_rx_rd #(.AW(AW), .RATIO(SLOW_RATIO)) u_rd (
    .clk(ref_clk), .rst_n(ref_rst_n), .slow(slow_mode), .code(start_code),
    .wgray_s(wgray_s), .head(head), .raddr(raddr), .rgray(rgray),
    .rxd(mac_rxd), .crs(mac_crs_dv), .dv(mac_rx_dv), .er(mac_rx_er),
    .pop(rd_pop), .ev_start(ev_start), .ev_ovf(ev_ovf), .ev_unf(ev_unf),
    .ev_eop(ev_eop)
  );
endmodule

// File: rtl/rmii_rx_elastic_chk.sv
`timescale 1ns/1ps
module rmii_rx_elastic_chk (
  input logic       ref_clk,
  input logic       ref_rst_n,
  input logic       slow_mode,
  input logic [1:0] mac_rxd,
  input logic       mac_crs_dv,
  input logic       mac_rx_dv,
  input logic       mac_rx_er,
  input logic       pop,
  input logic       ev_ovf,
  input logic       ev_unf
);
  p_idle_quiet_r8: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    !mac_crs_dv |-> (mac_rxd == 2'b00 && !mac_rx_dv && !mac_rx_er));

  p_dv_inside_crs_r4: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    mac_rx_dv |-> mac_crs_dv);

  p_overflow_flags_r6: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    ev_ovf |=> (mac_rx_er && mac_crs_dv));

  p_underflow_flags_r7: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    ev_unf |=> (mac_rx_er && mac_crs_dv));

  p_slow_hold_r3: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (slow_mode && mac_rx_dv && !mac_rx_er && $past(mac_rx_dv) && !$past(pop))
      |-> $stable(mac_rxd));
endmodule

bind rmii_rx_elastic rmii_rx_elastic_chk u_chk (
  .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .slow_mode(slow_mode),
  .mac_rxd(mac_rxd), .mac_crs_dv(mac_crs_dv), .mac_rx_dv(mac_rx_dv),
  .mac_rx_er(mac_rx_er), .pop(rd_pop), .ev_ovf(ev_ovf), .ev_unf(ev_unf)
);

// File: tb/rmii_rx_elastic_test.sv
`timescale 1ns/1ps
module rmii_rx_elastic_test;
  logic       ref_clk = 1'b0, rec_clk = 1'b0;
  logic       ref_rst_n = 1'b0, rec_rst_n = 1'b0;
  logic       rec_valid = 1'b0, rec_err = 1'b0, slow_mode = 1'b0;
  logic [1:0] rec_dibit = 2'b00, start_code = 2'd1;
  logic [1:0] mac_rxd;
  logic       mac_crs_dv, mac_rx_dv, mac_rx_er;

  real half_w = 4.0;
  int  nchk = 0, nfail = 0, cyc = 0;
  bit  done = 1'b0;

  rmii_rx_elastic uut (.*);

  always #4 ref_clk = ~ref_clk;
  initial begin #3; forever #(half_w) rec_clk = ~rec_clk; end

  // monitor state
  int cap_d[$];
  int cap_e[$];
  int wr_cnt, wr_at_crs, wr_at_dv, dv_len, er_cycles, sub, end_bad, idle_bad;
  bit dv_prev, crs_prev;

  task automatic clear_mon();
    cap_d.delete(); cap_e.delete();
    wr_cnt = 0; wr_at_crs = -1; wr_at_dv = -1; dv_len = 0; er_cycles = 0;
    sub = 0; end_bad = 0;
  endtask

  always @(negedge ref_clk) begin
    if (mac_crs_dv && !crs_prev) wr_at_crs = wr_cnt;
    if (mac_rx_dv && !dv_prev) begin wr_at_dv = wr_cnt; sub = 0; end
    if (mac_rx_dv) begin
      if (sub == 0) begin cap_d.push_back(int'(mac_rxd)); cap_e.push_back(int'(mac_rx_er)); end
      if (mac_rx_er) er_cycles++;
      dv_len++;
      sub = slow_mode ? ((sub == 9) ? 0 : sub + 1) : 0;
    end
    if (dv_prev && !mac_rx_dv && mac_crs_dv) end_bad++;
    if (crs_prev && !mac_crs_dv && mac_rx_dv) end_bad++;
    if (!mac_crs_dv && (mac_rxd != 2'b00 || mac_rx_dv || mac_rx_er)) idle_bad++;
    dv_prev  = mac_rx_dv;
    crs_prev = mac_crs_dv;
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  always @(posedge ref_clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1; nchk++; nfail++;
      $display("FAIL watchdog (all requirements): got %0d cycles, expected < 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_dibit(input int i, input int seed);
    return (i * seed + (i >> 2)) & 3;
  endfunction

  task automatic run_pkt(input logic [1:0] code, input int len, input int seed, input int errpos);
    start_code = code;
    repeat (4) @(negedge ref_clk);
    clear_mon();
    for (int i = 0; i < len; i++) begin
      @(negedge rec_clk);
      rec_valid = 1'b1;
      rec_dibit = 2'(exp_dibit(i, seed));
      rec_err   = (i == errpos);
      wr_cnt++;
    end
    @(negedge rec_clk);
    rec_valid = 1'b0; rec_err = 1'b0; rec_dibit = 2'b00;
    repeat (4) @(negedge ref_clk);
    for (int k = 0; k < 5000 && mac_crs_dv; k++) @(negedge ref_clk);
    repeat (10) @(negedge ref_clk);
  endtask

  task automatic check_data(input string req, input int len, input int seed);
    int bad = 0;
    check(cap_d.size() == len, req, cap_d.size(), len);
    for (int i = 0; i < cap_d.size() && i < len; i++)
      if (cap_d[i] != exp_dibit(i, seed)) bad++;
    check(bad == 0, req, bad, 0);
  endtask

  task automatic t_reset();
    check(mac_rxd == 2'b00 && !mac_crs_dv && !mac_rx_dv && !mac_rx_er, "R8 reset",
          {mac_rxd, mac_crs_dv, mac_rx_dv, mac_rx_er}, 0);
  endtask

  task automatic t_fast_data();
    run_pkt(2'd2, 30, 3, -1);
    check_data("R1 fast data", 30, 3);
    check(dv_len == 30, "R1 dv cycles", dv_len, 30);
    check(er_cycles == 0, "R5 no error", er_cycles, 0);
    check(end_bad == 0, "R10 end together", end_bad, 0);
  endtask

  task automatic t_thresholds();
    int base;
    int lv[4] = '{8, 2, 4, 6};
    run_pkt(2'd1, 30, 5, -1);
    base = wr_at_dv;
    check(wr_at_crs >= 0 && wr_at_crs < wr_at_dv, "R4 crs before dv", wr_at_crs, wr_at_dv);
    for (int c = 2; c <= 4; c++) begin
      int d;
      run_pkt(2'(c & 3), 30, 7, -1);
      d = wr_at_dv - base;
      check(d >= lv[c & 3] - 2 - 1 && d <= lv[c & 3] - 2 + 1, "R2 start level",
            d, lv[c & 3] - 2);
      check_data("R1 data per code", 30, 7);
    end
    check(wr_at_dv - wr_at_crs >= 6, "R4 crs leads dv at code 0", wr_at_dv - wr_at_crs, 7);
  endtask

  task automatic t_err_flag();
    int bad = 0;
    run_pkt(2'd2, 20, 1, 7);
    check(cap_e.size() == 20, "R5 err count", cap_e.size(), 20);
    for (int i = 0; i < cap_e.size(); i++) if (cap_e[i] != (i == 7)) bad++;
    check(bad == 0, "R5 err position", bad, 0);
  endtask

  task automatic t_slow();
    slow_mode = 1'b1; half_w = 40.0;
    repeat (30) @(negedge ref_clk);
    run_pkt(2'd1, 12, 3, -1);
    check(dv_len == 120, "R3 ten-clock hold", dv_len, 120);
    check_data("R3 slow data", 12, 3);
    check(end_bad == 0, "R10 slow end", end_bad, 0);
    slow_mode = 1'b0; half_w = 4.0;
    repeat (30) @(negedge ref_clk);
  endtask

  task automatic t_underflow();
    half_w = 4.25;
    repeat (10) @(negedge ref_clk);
    run_pkt(2'd1, 60, 2, -1);
    check(er_cycles > 0, "R7 underflow flagged", er_cycles, 1);
    check(!mac_crs_dv, "R9 flushed", mac_crs_dv, 0);
    half_w = 4.0;
    repeat (10) @(negedge ref_clk);
    run_pkt(2'd0, 25, 6, -1);
    check(er_cycles == 0, "R9 clean after error", er_cycles, 0);
    check_data("R9 data after error", 25, 6);
  endtask

  task automatic t_overflow();
    half_w = 3.75;
    repeat (10) @(negedge ref_clk);
    run_pkt(2'd1, 60, 3, -1);
    check(er_cycles > 0, "R6 overflow flagged", er_cycles, 1);
    half_w = 4.15;
    repeat (10) @(negedge ref_clk);
    run_pkt(2'd0, 40, 5, -1);
    check(er_cycles == 0, "R6 offset within margin", er_cycles, 0);
    check_data("R6 data within margin", 40, 5);
    half_w = 4.0;
    repeat (10) @(negedge ref_clk);
  endtask

  initial begin
    idle_bad = 0;
    clear_mon();
    repeat (3) @(negedge ref_clk);
    t_reset();
    ref_rst_n = 1'b1; rec_rst_n = 1'b1;
    repeat (5) @(negedge ref_clk);
    t_reset();
    t_fast_data();
    t_thresholds();
    t_err_flag();
    t_slow();
    t_underflow();
    t_overflow();
    check(idle_bad == 0, "R8 idle outputs", idle_bad, 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule